// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Memory Access

This block sits between one processor request port and a word-addressed local memory, and gives that port an atomic read-modify-write built from two separate operations. A linking load reads a word and sets a reservation on the block that holds it. A later conditional store writes only if the reservation still covers the same block, and reports whether it wrote. Plain loads and stores pass through as ordinary accesses.

The reservation is a valid bit plus a block number. It is lost when another agent is seen to invalidate the reserved block on the snoop input, when the processor takes an interrupt or switches context, and whenever a conditional store is issued. A spin lock or an atomic exchange in software retries the pair until the conditional store reports success. Matching is done per block: the lowest `BLK_OFF_W` address bits are ignored, so a conditional store to any word of the reserved block may succeed.

Every request gets one response exactly one clock later; memory is a single synchronous port so that it maps to block RAM.

Top module: `llsc_monitor`

## Requirements
- R1: A linking load (`req_op` = 2'b10) returns the word at `req_addr` on `rsp_rdata` one cycle later and sets the reservation to the block of `req_addr`.
- R2: A conditional store (`req_op` = 2'b11) writes `req_wdata` only if the reservation is valid and its block equals the block of `req_addr`; otherwise memory keeps its old value.
- R3: `rsp_sc_ok` is 1 in the response of a conditional store that wrote, 0 for one that did not, and 0 in every other response.
- R4: `irq_take` or `ctx_switch` high clears the reservation; in the same cycle as a conditional store it makes that store fail, and in the same cycle as a linking load it leaves the reservation invalid.
- R5: A snoop (`snoop_valid` with `snoop_blk`) that names the reserved block clears the reservation and, in the same cycle as a conditional store, makes that store fail; a snoop naming another block has no effect.
- R6: A linking load replaces any earlier reservation; a snoop naming the load's own block in the same cycle leaves the reservation invalid.
- R7: A conditional store clears the reservation whether or not it wrote.
- R8: A plain load (2'b00) returns the word one cycle later; a plain store (2'b01) always writes; neither changes the reservation, and `rsp_valid` is high exactly one cycle after each accepted request and low otherwise.
- R9: After synchronous reset the reservation is invalid and `rsp_valid` and `rsp_sc_ok` are 0.
- R10: The block of an address is `addr >> BLK_OFF_W` (default 2, four words per block); a conditional store to another word of the reserved block succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 linking load, 11 conditional store |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another agent invalidates a block |
| snoop_blk | input | ADDR_W-BLK_OFF_W | Block number being invalidated |
| irq_take | input | 1 | Interrupt taken by the processor |
| ctx_switch | input | 1 | Context switch |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | DATA_W | Read data for loads and linking loads |
| rsp_sc_ok | output | 1 | Conditional store wrote |

## Verification
The conflicts that matter are a conditional store or a linking load arriving in the same cycle as a snoop on the reserved block or an interrupt or context switch. Directed sequences force each pairing, and the random phase drives snoops on a handful of blocks together with frequent events so such coincidences occur hundreds of times. The bench model orders the snoop and the events after the load and before the store, so the expected result is a failed store and an invalid reservation, judged by the success flag and by reading the word back.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } mem_op_e;
endpackage

// File: rtl/llsc_mem.sv
// Single-port synchronous RAM, read-first, no reset so block RAM fits.
module llsc_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/llsc_link_reg.sv
// Reservation register: valid bit plus block number.
module llsc_link_reg #(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ll_fire,
  input  logic             sc_fire,
  input  logic             kill,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             snoop_valid,
  input  logic [BLK_W-1:0] snoop_blk,
  output logic             sc_pass,
  output logic             link_valid
);
  logic             valid_q;
  logic [BLK_W-1:0] blk_q;
  logic             snoop_hit;
  logic             ll_snooped;

  assign snoop_hit  = snoop_valid && valid_q && (snoop_blk == blk_q);
  assign ll_snooped = snoop_valid && (snoop_blk == req_blk);
  assign sc_pass    = sc_fire && valid_q && (blk_q == req_blk) && !snoop_hit && !kill;
  assign link_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
    end else if (kill) begin
      valid_q <= 1'b0;
    end else if (ll_fire) begin
      valid_q <= !ll_snooped;
      blk_q   <= req_blk;
    end else if (sc_fire) begin
      valid_q <= 1'b0;
    end else if (snoop_hit) begin
      valid_q <= 1'b0;
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> !valid_q);
  a_r4_event_clears: assert property (@(posedge clk) disable iff (rst)
    kill |=> !valid_q);
  a_r5_snoop_clears: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && valid_q && snoop_blk == blk_q && !ll_fire) |=> !valid_q);
  a_r7_cond_consumes: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> !valid_q);
  a_r6_link_sets: assert property (@(posedge clk) disable iff (rst)
    (ll_fire && !kill && !(snoop_valid && snoop_blk == req_blk))
      |=> (valid_q && blk_q == $past(req_blk)));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BLK_OFF_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic                        snoop_valid,
  input  logic [ADDR_W-BLK_OFF_W-1:0] snoop_blk,
  input  logic                        irq_take,
  input  logic                        ctx_switch,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic                        rsp_sc_ok
);
  import llsc_pkg::*;

  localparam int BLK_W = ADDR_W - BLK_OFF_W;

  mem_op_e    op;
  logic       ll_fire, sc_fire, st_fire, kill;
  logic       sc_pass, link_valid, mem_we;
  logic [BLK_W-1:0] req_blk;

  assign op      = mem_op_e'(req_op);
  assign ll_fire = req_valid && (op == OP_LINK);
  assign sc_fire = req_valid && (op == OP_COND);
  assign st_fire = req_valid && (op == OP_STORE);
  assign kill    = irq_take || ctx_switch;
  assign req_blk = req_addr[ADDR_W-1:BLK_OFF_W];
  assign mem_we  = st_fire || sc_pass;

  llsc_link_reg #(.BLK_W(BLK_W)) link_i (
    .clk        (clk),
    .rst        (rst),
    .ll_fire    (ll_fire),
    .sc_fire    (sc_fire),
    .kill       (kill),
    .req_blk    (req_blk),
    .snoop_valid(snoop_valid),
    .snoop_blk  (snoop_blk),
    .sc_pass    (sc_pass),
    .link_valid (link_valid)
  );

  llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk  (clk),
    .we   (mem_we),
    .addr (req_addr),
    .wdata(req_wdata),
    .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sc_ok <= sc_pass;
    end
  end

  a_r2_fail_no_write: assert property (@(posedge clk) disable iff (rst)
    (sc_fire && !sc_pass) |-> !mem_we);
  a_r3_flag_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> (rsp_valid && $past(link_valid)));
  a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
endmodule

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [5:0]  snoop_blk = '0;
  logic        irq_take = 1'b0;
  logic        ctx_switch = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_sc_ok;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] m_mem [16];
  logic        m_lv = 1'b0;
  logic [5:0]  m_lb = '0;

  always #5 clk = ~clk;

  llsc_monitor dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_blk(snoop_blk), .irq_take(irq_take), .ctx_switch(ctx_switch),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
  );

  function automatic logic [5:0] blk_of(input logic [7:0] a);
    return a[7:2];
  endfunction

  function automatic logic cond_passes(input logic [7:0] a, input logic sv,
                                       input logic [5:0] sb, input logic ev);
    logic hit;
    hit = sv && m_lv && (sb == m_lb);
    return m_lv && (m_lb == blk_of(a)) && !hit && !ev;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [1:0] op, input logic [7:0] a,
                      input logic [31:0] wd, input logic sv, input logic [5:0] sb,
                      input logic ir, input logic cx, input string tag);
    logic        ev, ok, hit, is_rd;
    logic [31:0] exp_rd;
    ev     = ir || cx;
    hit    = sv && m_lv && (sb == m_lb);
    ok     = rv && (op == 2'b11) && cond_passes(a, sv, sb, ev);
    is_rd  = rv && (op == 2'b00 || op == 2'b10);
    exp_rd = m_mem[a[3:0]];
    if (rv && (op == 2'b01 || ok)) m_mem[a[3:0]] = wd;
    if (ev) m_lv = 1'b0;
    else if (rv && op == 2'b10) begin
      m_lv = !(sv && sb == blk_of(a));
      m_lb = blk_of(a);
    end else if (rv && op == 2'b11) m_lv = 1'b0;
    else if (hit) m_lv = 1'b0;
    req_valid = rv; req_op = op; req_addr = a; req_wdata = wd;
    snoop_valid = sv; snoop_blk = sb; irq_take = ir; ctx_switch = cx;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0; irq_take = 1'b0; ctx_switch = 1'b0;
    check(rsp_valid == rv, tag, "rsp_valid", 32'(rsp_valid), 32'(rv));
    check(rsp_sc_ok == ok, tag, "rsp_sc_ok", 32'(rsp_sc_ok), 32'(ok));
    if (is_rd) check(rsp_rdata == exp_rd, tag, "rsp_rdata", rsp_rdata, exp_rd);
  endtask

  task automatic ld(input logic [7:0] a, input string tag);
    step(1'b1, 2'b00, a, '0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask
  task automatic st(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 2'b01, a, d, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask
  task automatic ll(input logic [7:0] a, input string tag);
    step(1'b1, 2'b10, a, '0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask
  task automatic sc(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 2'b11, a, d, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog R9: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", 32'(rsp_valid), 0);
    check(rsp_sc_ok == 1'b0, "R9", "rsp_sc_ok in reset", 32'(rsp_sc_ok), 0);
    rst = 1'b0;
    sc(8'd3, 32'hDEAD_0003, "R9");          // no reservation after reset
    for (int i = 0; i < 16; i++) st(8'(i), 32'h100 + i, "R8");
    ld(8'd5, "R8");
    step(1'b0, 2'b00, 8'd0, '0, 1'b0, '0, 1'b0, 1'b0, "R8"); // idle
    // link then conditional store to other word of same block
    ll(8'd4, "R1");
    sc(8'd6, 32'hAAAA, "R10");
    ld(8'd6, "R2");
    sc(8'd6, 32'hBBBB, "R7");
    ld(8'd6, "R2");
    sc(8'd9, 32'hCCCC, "R3");
    ld(8'd9, "R2");
    // snoops
    ll(8'd8, "R1");
    step(1'b0, 2'b00, 8'd0, '0, 1'b1, 6'd3, 1'b0, 1'b0, "R5");
    sc(8'd8, 32'h1111, "R5");
    ll(8'd8, "R1");
    step(1'b0, 2'b00, 8'd0, '0, 1'b1, 6'd2, 1'b0, 1'b0, "R5");
    sc(8'd8, 32'h2222, "R5");
    ll(8'd8, "R1");
    step(1'b1, 2'b11, 8'd8, 32'h3333, 1'b1, 6'd2, 1'b0, 1'b0, "R5");
    ld(8'd8, "R2");
    step(1'b1, 2'b10, 8'd8, '0, 1'b1, 6'd2, 1'b0, 1'b0, "R6");
    sc(8'd8, 32'h4444, "R6");
    // overwrite
    ll(8'd0, "R6"); ll(8'd12, "R6"); sc(8'd0, 32'h5555, "R6");
    ll(8'd0, "R6"); ll(8'd12, "R6"); sc(8'd12, 32'h6666, "R6");
    // interrupt and context switch
    ll(8'd1, "R4");
    step(1'b0, 2'b00, 8'd0, '0, 1'b0, '0, 1'b1, 1'b0, "R4");
    sc(8'd1, 32'h7777, "R4");
    ll(8'd1, "R4");
    step(1'b0, 2'b00, 8'd0, '0, 1'b0, '0, 1'b0, 1'b1, "R4");
    sc(8'd1, 32'h8888, "R4");
    ll(8'd1, "R4");
    step(1'b1, 2'b11, 8'd1, 32'h9999, 1'b0, '0, 1'b1, 1'b0, "R4");
    step(1'b1, 2'b10, 8'd1, '0, 1'b0, '0, 1'b0, 1'b1, "R4");
    sc(8'd1, 32'h9A9A, "R4");
    ld(8'd1, "R4");
    // plain traffic does not disturb reservation
    ll(8'd13, "R1"); st(8'd13, 32'hCAFE, "R8"); ld(8'd13, "R8");
    sc(8'd13, 32'hBEEF, "R8"); ld(8'd13, "R8");
    ll(8'd14, "R2"); sc(8'd2, 32'hF00D, "R2"); ld(8'd2, "R2");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] op;
      logic       rv, sv, ir, cx;
      op = 2'($urandom_range(0, 3));
      rv = ($urandom_range(0, 9) != 0);
      sv = ($urandom_range(0, 3) == 0);
      ir = ($urandom_range(0, 24) == 0);
      cx = ($urandom_range(0, 24) == 0);
      step(rv, op, 8'($urandom_range(0, 15)), $urandom, sv,
           6'($urandom_range(0, 3)), ir, cx, (op == 2'b11) ? "R3" : "R1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule